// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block caches page table entries in a fully associative array so that a virtual page number can be turned into a physical page number within the same cycle. Each slot holds the following fields:

- a valid flag
- a virtual page tag
- a physical page number
- an address-space identifier
- a global flag that makes the entry visible to every address space
- per-mode read and write enable masks

A lookup presents a page number together with the current address-space identifier. The block returns whether the pair hits, which slot hit, and that slot's fields.

A miss handler refills the array. New entries always land in the slot named by a rotating next-victim pointer. A separate index port exposes the slot under the pointer, and it can step the pointer on request. Three invalidation commands keep the array coherent with page table changes:

- flush everything
- flush every non-global entry
- flush one page in one address space

The block does no page walking, no permission checking and no address formation. Its consumers do those jobs with the fields it returns. Typical builds use a 48-entry instance on the instruction side and a 64-entry instance on the data side.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits only when some slot is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored identifier equals `lk_asn`. `lk_hit` and the returned fields follow the lookup inputs combinationally, with no clock edge in between.
- R2: When several slots hit, `lk_idx` names the lowest-numbered one, and `lk_ppn`, `lk_glob`, `lk_rd_en` and `lk_wr_en` come from that slot.
- R3: An accepted insert writes the slot at the current pointer and marks it valid, replacing whatever that slot held. The tag is the page-number field `ins_va[VA_W-1:OFS_W]`; the low `OFS_W` offset bits are ignored.
- R4: Each accepted insert advances the pointer by one, and the pointer wraps from DEPTH-1 to 0.
- R5: The index port shows the slot under the pointer. `ix_adv` steps the pointer by one with the same wrap. An insert and `ix_adv` in the same cycle step it by one in total. With neither asserted, the pointer holds.
- R6: `fl_cmd` = 2'b01 (flush all) clears every valid flag and returns the pointer to 0.
- R7: `fl_cmd` = 2'b10 (flush processes) invalidates every slot whose global flag is clear and leaves global slots valid and unchanged.
- R8: `fl_cmd` = 2'b11 (flush address) invalidates exactly the slots that would hit a lookup of `fl_vpn` under `fl_asn` by the rule of R1; all other slots keep their state.
- R9: While `fl_cmd` is not 2'b00, `ins_en` is ignored: no slot is written and the insert does not move the pointer.
- R10: After reset every slot is invalid and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Slot that hit (lowest index) |
| lk_ppn | output | PPN_W | Physical page number of the hit slot |
| lk_glob | output | 1 | Global flag of the hit slot |
| lk_rd_en | output | MODES | Read enables of the hit slot |
| lk_wr_en | output | MODES | Write enables of the hit slot |
| ins_en | input | 1 | Insert request |
| ins_va | input | VA_W | Virtual address supplying the new tag |
| ins_ppn | input | PPN_W | Physical page number to insert |
| ins_asn | input | ASN_W | Identifier to insert |
| ins_glob | input | 1 | Global flag to insert |
| ins_rd_en | input | MODES | Read enables to insert |
| ins_wr_en | input | MODES | Write enables to insert |
| fl_cmd | input | 2 | 00 none, 01 all, 10 non-global, 11 one address |
| fl_vpn | input | VPN_W | Page number for flush-address |
| fl_asn | input | ASN_W | Identifier for flush-address |
| ix_adv | input | 1 | Step the pointer |
| ix_ptr | output | IDX_W | Current next-victim pointer |
| ix_valid | output | 1 | Valid flag of the slot under the pointer |
| ix_vpn | output | VPN_W | Tag of the slot under the pointer |
| ix_ppn | output | PPN_W | Physical page of the slot under the pointer |
| ix_asn | output | ASN_W | Identifier of the slot under the pointer |
| ix_glob | output | 1 | Global flag of the slot under the pointer |
| ix_rd_en | output | MODES | Read enables of the slot under the pointer |
| ix_wr_en | output | MODES | Write enables of the slot under the pointer |

## Verification
The bench builds the block with four slots, 4-bit page numbers, 2-bit identifiers, two modes and 2 offset bits. With that shape, every lookup key (16 pages by 4 identifiers) can be swept after each state change. This covers every hit, every miss and every multi-hit priority case. The small depth lets the pointer wrap many times, so insert/flush collisions and pointer-step combinations all occur within a few thousand cycles.

// File: rtl/tlb_pkg.sv
// Shared definitions for the address-space-tagged translation buffer.
// Assumes the two-bit flush command encoding is fixed across the chip.
package tlb_pkg;

    typedef enum logic [1:0] {
        FL_NONE = 2'b00,
        FL_ALL  = 2'b01,
        FL_PROC = 2'b10,
        FL_ADDR = 2'b11
    } flush_cmd_e;

endpackage

// File: rtl/tlb_cam_match.sv
// Parallel tag comparator: flags every slot that is valid, carries the key
// page number, and is global or owned by the key identifier.
// Assumes the stored arrays are packed one slot per row.
module tlb_cam_match #(
    parameter int N     = 4,
    parameter int VPN_W = 8,
    parameter int ASN_W = 4
) (
    input  logic [N-1:0]            valid,
    input  logic [N-1:0]            glob,
    input  logic [N-1:0][VPN_W-1:0] tags,
    input  logic [N-1:0][ASN_W-1:0] asns,
    input  logic [VPN_W-1:0]        key_vpn,
    input  logic [ASN_W-1:0]        key_asn,
    output logic [N-1:0]            hits
);

    // One comparator per slot.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = valid[g] && (tags[g] == key_vpn) &&
                         (glob[g] || (asns[g] == key_asn));
    end

endmodule

// File: rtl/tlb_first_one.sv
// Fixed-priority encoder: reports whether any request is set and the index
// of the lowest set request. Index is zero when nothing is set.
module tlb_first_one #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] req,
    output logic         found,
    output logic [W-1:0] idx
);

    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end

    assign found = |req;

endmodule

// File: rtl/tlb_victim_ptr.sv
// Rotating next-victim pointer. Clears to zero on request, otherwise steps
// by one with wrap at DEPTH-1. Synchronous active-low reset.
module tlb_victim_ptr #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    // Pointer register: clear beats step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clear) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/asn_tlb.sv
// Fully associative translation buffer with address-space tags.
// Lookup is combinational; inserts, flushes and pointer steps take effect
// at the next rising edge. A flush command suppresses a concurrent insert.
// Assumes callers treat lookup fields as meaningless when lk_hit is low.
module asn_tlb
    import tlb_pkg::*;
#(
    parameter int DEPTH = 48,
    parameter int VPN_W = 30,
    parameter int PPN_W = 28,
    parameter int ASN_W = 8,
    parameter int MODES = 4,
    parameter int OFS_W = 13,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int VA_W  = VPN_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [PPN_W-1:0] lk_ppn,
    output logic             lk_glob,
    output logic [MODES-1:0] lk_rd_en,
    output logic [MODES-1:0] lk_wr_en,
    input  logic             ins_en,
    input  logic [VA_W-1:0]  ins_va,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_glob,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic [1:0]       fl_cmd,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] fl_asn,
    input  logic             ix_adv,
    output logic [IDX_W-1:0] ix_ptr,
    output logic             ix_valid,
    output logic [VPN_W-1:0] ix_vpn,
    output logic [PPN_W-1:0] ix_ppn,
    output logic [ASN_W-1:0] ix_asn,
    output logic             ix_glob,
    output logic [MODES-1:0] ix_rd_en,
    output logic [MODES-1:0] ix_wr_en
);

    flush_cmd_e cmd;
    logic       ins_go;
    logic       unused_ofs;

    logic [DEPTH-1:0]            valid_q;
    logic [DEPTH-1:0]            glob_q;
    logic [DEPTH-1:0][VPN_W-1:0] tag_q;
    logic [DEPTH-1:0][PPN_W-1:0] ppn_q;
    logic [DEPTH-1:0][ASN_W-1:0] asn_q;
    logic [DEPTH-1:0][MODES-1:0] rd_q;
    logic [DEPTH-1:0][MODES-1:0] wr_q;

    logic [DEPTH-1:0] lk_match;
    logic [DEPTH-1:0] fl_match;
    logic [IDX_W-1:0] ptr;

    assign cmd        = flush_cmd_e'(fl_cmd);
    assign ins_go     = ins_en && (cmd == FL_NONE);
    assign unused_ofs = ^ins_va[OFS_W-1:0];

    // Comparator bank for the lookup port.
    tlb_cam_match #(.N(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_cam (
        .valid   (valid_q),
        .glob    (glob_q),
        .tags    (tag_q),
        .asns    (asn_q),
        .key_vpn (lk_vpn),
        .key_asn (lk_asn),
        .hits    (lk_match)
    );

    // Comparator bank for the single-address flush.
    tlb_cam_match #(.N(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_cam (
        .valid   (valid_q),
        .glob    (glob_q),
        .tags    (tag_q),
        .asns    (asn_q),
        .key_vpn (fl_vpn),
        .key_asn (fl_asn),
        .hits    (fl_match)
    );

    // Lowest-index hit selection.
    tlb_first_one #(.N(DEPTH), .W(IDX_W)) u_prio (
        .req   (lk_match),
        .found (lk_hit),
        .idx   (lk_idx)
    );

    // Next-victim pointer, shared by insert and the index port.
    tlb_victim_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cmd == FL_ALL),
        .step  (ins_go || ix_adv),
        .ptr   (ptr)
    );

    // Entry storage: flushes first, otherwise an insert at the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            glob_q  <= '0;
            tag_q   <= '0;
            ppn_q   <= '0;
            asn_q   <= '0;
            rd_q    <= '0;
            wr_q    <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                case (cmd)
                    FL_ALL:  valid_q[i] <= 1'b0;
                    FL_PROC: if (!glob_q[i]) valid_q[i] <= 1'b0;
                    FL_ADDR: if (fl_match[i]) valid_q[i] <= 1'b0;
                    default: begin
                        if (ins_go && (ptr == IDX_W'(i))) begin
                            valid_q[i] <= 1'b1;
                            glob_q[i]  <= ins_glob;
                            tag_q[i]   <= ins_va[VA_W-1:OFS_W];
                            ppn_q[i]   <= ins_ppn;
                            asn_q[i]   <= ins_asn;
                            rd_q[i]    <= ins_rd_en;
                            wr_q[i]    <= ins_wr_en;
                        end
                    end
                endcase
            end
        end
    end

    // Lookup field mux driven by the priority encoder.
    always_comb begin
        lk_ppn   = ppn_q[lk_idx];
        lk_glob  = glob_q[lk_idx];
        lk_rd_en = rd_q[lk_idx];
        lk_wr_en = wr_q[lk_idx];
    end

    // Index port view of the slot under the pointer.
    always_comb begin
        ix_ptr   = ptr;
        ix_valid = valid_q[ptr];
        ix_vpn   = tag_q[ptr];
        ix_ppn   = ppn_q[ptr];
        ix_asn   = asn_q[ptr];
        ix_glob  = glob_q[ptr];
        ix_rd_en = rd_q[ptr];
        ix_wr_en = wr_q[ptr];
    end

endmodule

// File: rtl/asn_tlb_chk.sv
// Temporal checks for asn_tlb, attached by bind below.
module asn_tlb_chk
    import tlb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ins_en,
    input logic             ix_adv,
    input logic [1:0]       fl_cmd,
    input logic [IDX_W-1:0] ix_ptr,
    input logic             lk_hit,
    input logic [IDX_W-1:0] lk_idx,
    input logic [DEPTH-1:0] lk_match,
    input logic [DEPTH-1:0] valid_vec,
    input logic [DEPTH-1:0] glob_vec
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    // R2
    lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_match[lk_idx] &&
                    ((lk_match & ((DEPTH'(1) << lk_idx) - DEPTH'(1))) == '0)));

    // R3
    insert_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && fl_cmd == FL_NONE) |=> valid_vec[$past(ix_ptr)]);

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && fl_cmd == FL_NONE) |=>
        (ix_ptr == (($past(ix_ptr) == LAST) ? '0 : $past(ix_ptr) + 1'b1)));

    // R5
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_en && !ix_adv && fl_cmd != FL_ALL) |=> $stable(ix_ptr));

    // R6
    flush_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd == FL_ALL) |=> (ix_ptr == '0 && valid_vec == '0));

    // R7
    flush_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_cmd == FL_PROC) |=> (valid_vec == ($past(valid_vec) & $past(glob_vec))));

    // R9
    flush_blocks_ins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && fl_cmd != FL_NONE && fl_cmd != FL_ALL && !ix_adv) |=> $stable(ix_ptr));

endmodule

bind asn_tlb asn_tlb_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_en    (ins_en),
    .ix_adv    (ix_adv),
    .fl_cmd    (fl_cmd),
    .ix_ptr    (ix_ptr),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .lk_match  (lk_match),
    .valid_vec (valid_q),
    .glob_vec  (glob_q)
);

// File: tb/asn_tlb_test.sv
`timescale 1ns/1ps
// Bench for asn_tlb: four slots, full key sweeps after every state change.
module asn_tlb_test;

    localparam int D = 4, VW = 4, PW = 4, AW = 2, MW = 2, OW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [VW-1:0] lk_vpn = '0;
    logic [AW-1:0] lk_asn = '0;
    logic lk_hit, lk_glob, ix_valid, ix_glob;
    logic [1:0] lk_idx, ix_ptr;
    logic [PW-1:0] lk_ppn, ix_ppn, ins_ppn = '0;
    logic [MW-1:0] lk_rd_en, lk_wr_en, ix_rd_en, ix_wr_en;
    logic ins_en = 1'b0, ins_glob = 1'b0, ix_adv = 1'b0;
    logic [VW+OW-1:0] ins_va = '0;
    logic [AW-1:0] ins_asn = '0, fl_asn = '0, ix_asn;
    logic [MW-1:0] ins_rd_en = '0, ins_wr_en = '0;
    logic [1:0] fl_cmd = 2'b00;
    logic [VW-1:0] fl_vpn = '0, ix_vpn;

    int nchk = 0, nfail = 0;
    int mv[D], mt[D], mp[D], ma[D], mg[D], mr[D], mw[D];
    int mptr = 0;

    always #2 clk = ~clk;

    asn_tlb #(.DEPTH(D), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .MODES(MW), .OFS_W(OW)) uut (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit),
        .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_glob(lk_glob), .lk_rd_en(lk_rd_en),
        .lk_wr_en(lk_wr_en), .ins_en(ins_en), .ins_va(ins_va), .ins_ppn(ins_ppn),
        .ins_asn(ins_asn), .ins_glob(ins_glob), .ins_rd_en(ins_rd_en),
        .ins_wr_en(ins_wr_en), .fl_cmd(fl_cmd), .fl_vpn(fl_vpn), .fl_asn(fl_asn),
        .ix_adv(ix_adv), .ix_ptr(ix_ptr), .ix_valid(ix_valid), .ix_vpn(ix_vpn),
        .ix_ppn(ix_ppn), .ix_asn(ix_asn), .ix_glob(ix_glob), .ix_rd_en(ix_rd_en),
        .ix_wr_en(ix_wr_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected hit per R1/R2: lowest valid slot with tag and (global or ASN) match.
    task automatic sweep(input string req);
        for (int v = 0; v < 16; v++) begin
            for (int a = 0; a < 4; a++) begin
                int eh = 0, ei = 0;
                lk_vpn = VW'(v);
                lk_asn = AW'(a);
                for (int i = D - 1; i >= 0; i--)
                    if (mv[i] != 0 && mt[i] == v && (mg[i] != 0 || ma[i] == a)) begin
                        eh = 1; ei = i;
                    end
                #1;
                chk(int'(lk_hit) == eh, req, "lk_hit", int'(lk_hit), eh);
                if (eh != 0) begin
                    chk(int'(lk_idx) == ei, "R2", "lk_idx", int'(lk_idx), ei);
                    chk(int'(lk_ppn) == mp[ei] && int'(lk_glob) == mg[ei] &&
                        int'(lk_rd_en) == mr[ei] && int'(lk_wr_en) == mw[ei],
                        "R2", "lk fields(ppn)", int'(lk_ppn), mp[ei]);
                end
            end
        end
    endtask

    task automatic chk_ix(input string req);
        #1;
        chk(int'(ix_ptr) == mptr, req, "ix_ptr", int'(ix_ptr), mptr);
        chk(int'(ix_valid) == mv[mptr], req, "ix_valid", int'(ix_valid), mv[mptr]);
        if (mv[mptr] != 0)
            chk(int'(ix_vpn) == mt[mptr] && int'(ix_ppn) == mp[mptr] &&
                int'(ix_asn) == ma[mptr] && int'(ix_glob) == mg[mptr] &&
                int'(ix_rd_en) == mr[mptr] && int'(ix_wr_en) == mw[mptr],
                "R5", "ix fields(vpn)", int'(ix_vpn), mt[mptr]);
    endtask

    // One clock of stimulus, with the bench model advanced per R3-R9.
    task automatic step(input int ins, input int vpn, input int asn, input int ppn,
                        input int g, input int rd, input int wr, input int adv,
                        input int cmd, input int fvpn, input int fasn);
        @(negedge clk);
        ins_en = ins[0]; ins_va = {VW'(vpn), 2'b10}; ins_asn = AW'(asn);
        ins_ppn = PW'(ppn); ins_glob = g[0]; ins_rd_en = MW'(rd); ins_wr_en = MW'(wr);
        ix_adv = adv[0]; fl_cmd = 2'(cmd); fl_vpn = VW'(fvpn); fl_asn = AW'(fasn);
        @(posedge clk);
        if (cmd == 1) begin
            for (int i = 0; i < D; i++) mv[i] = 0;
            mptr = 0;
        end else begin
            for (int i = 0; i < D; i++) begin
                if (cmd == 2 && mg[i] == 0) mv[i] = 0;
                if (cmd == 3 && mv[i] != 0 && mt[i] == fvpn && (mg[i] != 0 || ma[i] == fasn))
                    mv[i] = 0;
            end
            if (cmd == 0 && ins != 0) begin
                mv[mptr] = 1; mt[mptr] = vpn; ma[mptr] = asn; mp[mptr] = ppn;
                mg[mptr] = g; mr[mptr] = rd; mw[mptr] = wr;
            end
            if ((cmd == 0 && ins != 0) || adv != 0) mptr = (mptr + 1) % D;
        end
        #1;
        ins_en = 1'b0; ix_adv = 1'b0; fl_cmd = 2'b00;
    endtask

    initial begin
        #(4 * 200000);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int lf = 16'hACE1;
        for (int i = 0; i < D; i++) begin
            mv[i] = 0; mt[i] = 0; mp[i] = 0; ma[i] = 0; mg[i] = 0; mr[i] = 0; mw[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R10: empty and pointer zero after reset
        chk_ix("R10");
        sweep("R10");
        // R3/R4: fill all slots; slots 0 and 3 both match page 3 / ASN 1
        step(1, 3, 1, 9, 0, 1, 2, 0, 0, 0, 0);  chk_ix("R4");
        step(1, 5, 2, 7, 1, 3, 0, 0, 0, 0, 0);  chk_ix("R4");
        step(1, 3, 2, 4, 0, 2, 1, 0, 0, 0, 0);  chk_ix("R4");
        step(1, 3, 0, 12, 1, 0, 3, 0, 0, 0, 0); chk_ix("R4"); // wrap to 0
        sweep("R1");
        // R5: pointer steps on request, holds otherwise; insert+adv = one step
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0); chk_ix("R5");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0); chk_ix("R5");
        step(1, 9, 3, 6, 0, 1, 1, 1, 0, 0, 0); chk_ix("R5");
        // R3: overwrite of a valid slot
        step(1, 5, 1, 2, 0, 3, 3, 0, 0, 0, 0); chk_ix("R3");
        sweep("R3");
        // R9: insert during flush-address is dropped
        step(1, 7, 1, 1, 1, 1, 1, 0, 3, 3, 1); chk_ix("R9");
        sweep("R8");
        // R9: insert during flush-processes is dropped
        step(1, 8, 0, 5, 0, 2, 2, 0, 2, 0, 0); chk_ix("R9");
        sweep("R7");
        // R6: flush-all from a nonzero pointer
        step(1, 2, 2, 3, 0, 1, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        step(1, 4, 2, 3, 0, 1, 0, 1, 1, 0, 0); chk_ix("R6");
        sweep("R6");
        // Pseudo-random mix of all operations
        for (int n = 0; n < 300; n++) begin
            int op;
            lf = ((lf << 1) | (((lf >> 15) ^ (lf >> 13) ^ (lf >> 12) ^ (lf >> 10)) & 1)) & 16'hFFFF;
            op = lf % 16;
            step(op < 10 ? 1 : 0, (lf >> 4) % 6, (lf >> 7) % 4, (lf >> 9) % 16,
                 ((lf >> 11) % 3 == 0) ? 1 : 0, (lf >> 12) % 4, (lf >> 2) % 4,
                 (lf >> 14) % 3 == 0 ? 1 : 0,
                 op == 15 ? 1 : (op == 14 ? 2 : (op >= 11 ? 3 : 0)),
                 (lf >> 5) % 6, (lf >> 1) % 4);
            chk_ix("R5");
            sweep(op >= 11 ? "R8" : "R1");
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule